// File: doc/BRIEF.md
# Resolution-Multiplier Watchdog Timer

This block supervises a host processor through a single 8-bit configuration register. The register holds a 5-bit binary multiplier and a 3-bit resolution code. The timeout period is the multiplier times the period of the selected resolution. The block does not divide down a crystal itself. It receives one tick-enable line per resolution, each high for one clock cycle per period, and counts only the line that the resolution code selects.

The host keeps the system alive by writing the register again before the period runs out. Every write starts a fresh period. If the count runs out, the block raises its interrupt output and sets a sticky watchdog flag. The interrupt stays high until the next register write. The flag is cleared when the host reads the flags register, where it sits in bit 7. After a timeout the counter halts until the register is written again.

Certain register values never time out: the value 00h, and any resolution code outside the five defined ones. A zero multiplier combined with a defined resolution code other than the fastest one times out at once.

Top module: `wdt_resmul`

## Requirements
- R1: After reset `cfg_rdata` is 00h, `wdt_irq` is 0 and `wdt_flag` is 0, and no timeout occurs until the register is written.
- R2: The register layout is: resolution code bit 2 in register bit 7, multiplier in bits 6:2, resolution code bits 1:0 in bits 1:0. Resolution codes 0 to 4 select `tick_en[0]` (1/16 s), `tick_en[1]` (1/4 s), `tick_en[2]` (1 s), `tick_en[3]` (4 s) and `tick_en[4]` (1 min). After a write with multiplier M ≥ 1, `wdt_irq` and `wdt_flag` rise at the clock edge that samples the M-th high cycle of the selected tick line. Ticks on unselected lines have no effect. Example: 0x0E gives 3 ticks of 1 s.
- R3: Resolution codes 5, 6 and 7 never produce a timeout, whatever the ticks and the multiplier.
- R4: A write with multiplier 0 and resolution code 1 to 4 sets `wdt_irq` and `wdt_flag` at the clock edge that accepts the write.
- R5: Any register write restarts the period from the new multiplier and clears `wdt_irq`, except when R4 applies. The written value is visible on `cfg_rdata` after that edge.
- R6: Writing 00h disables the watchdog. No timeout occurs until a new value is written.
- R7: A cycle with `flag_rd` high clears `wdt_flag` at the next edge. If a timeout occurs in the same cycle, the flag is set instead.
- R8: After a timeout, `wdt_irq` stays high until the next write, and the count stays halted. Further ticks do not set the flag again after it has been read.
- R9: A tick on the selected line in the same cycle as a register write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 5 | One-cycle tick per resolution; index equals the resolution code |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| flag_rd | input | 1 | Flags register read strobe (clears the flag) |
| cfg_rdata | output | 8 | Current register value |
| wdt_irq | output | 1 | Timeout interrupt, active high, held until the next write |
| wdt_flag | output | 1 | Sticky watchdog flag (bit 7 of the flags register) |

## Verification
The assertions rely on three assumptions: reset is applied from time zero, every input is a defined 0 or 1 at each sampling edge, and a write strobe always carries meaningful data. They make no assumption about how the tick lines relate to each other, so several ticks may be high in the same cycle. The stimulus changes inputs only on the falling clock edge. Tick lines are drawn independently at random, and register values are biased toward small multipliers so that timeouts, immediate timeouts and the undefined resolution codes all occur often. Writes and flag reads are scattered through the run, so they land both on expiry cycles and on tick cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CFG_W     = 8;
  localparam int MULT_W    = 5;
  localparam int RES_W     = 3;
  localparam int NUM_RES   = 5;
  localparam int MULT_LSB  = 2;
  localparam int RES_HI_AT = 7;

  typedef struct packed {
    logic [RES_W-1:0]  res;
    logic [MULT_W-1:0] mult;
    logic              res_ok;
    logic              fire_now;
    logic              arm;
  } wdt_dec_t;
endpackage

// File: rtl/wdt_cfg_decode.sv
module wdt_cfg_decode
  import wdt_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int MW = MULT_W,
  parameter int RW = RES_W,
  parameter int NR = NUM_RES
) (
  input  logic [CW-1:0] raw,
  output wdt_dec_t      dec
);
  localparam int LOW_RES = RW - 1;

  logic [RW-1:0] res_w;
  logic [MW-1:0] mult_w;
  logic          ok_w;
  logic          zero_m;
  logic          off_w;

  always_comb begin
    res_w  = {raw[RES_HI_AT], raw[LOW_RES-1:0]};
    mult_w = raw[MULT_LSB +: MW];
    ok_w   = (32'(res_w) < NR);
    zero_m = (mult_w == '0);
    off_w  = (raw == '0);
    dec.res      = res_w;
    dec.mult     = mult_w;
    dec.res_ok   = ok_w;
    dec.fire_now = ok_w && zero_m && (res_w != '0);
    dec.arm      = ok_w && !zero_m && !off_w;
  end
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int NR = NUM_RES
) (
  input  logic [NR-1:0] tick_en,
  input  logic [RW-1:0] res,
  output logic          tick
);
  logic [NR-1:0] hit;

  for (genvar i = 0; i < NR; i++) begin : g_res
    assign hit[i] = tick_en[i] && (res == RW'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int MW = MULT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_arm,
  input  logic [MW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [MW-1:0] cnt_q;
  logic          run_q;
  logic          last;

  assign last   = (cnt_q == MW'(1));
  assign expire = !load && run_q && tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= load_arm;
    end else if (run_q && tick) begin
      if (last) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - MW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_resmul.sv
module wdt_resmul
  import wdt_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int MW = MULT_W,
  parameter int RW = RES_W,
  parameter int NR = NUM_RES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] tick_en,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          flag_rd,
  output logic [CW-1:0] cfg_rdata,
  output logic          wdt_irq,
  output logic          wdt_flag
);
  logic [CW-1:0] cfg_q;
  wdt_dec_t      cur_dec;
  wdt_dec_t      new_dec;
  logic          sel_tick;
  logic          expire;
  logic          irq_q;
  logic          flag_q;
  logic          set_ev;

  wdt_cfg_decode #(.CW(CW), .MW(MW), .RW(RW), .NR(NR)) u_dec_cur (
    .raw (cfg_q),
    .dec (cur_dec)
  );

  wdt_cfg_decode #(.CW(CW), .MW(MW), .RW(RW), .NR(NR)) u_dec_new (
    .raw (cfg_wdata),
    .dec (new_dec)
  );

  wdt_tick_sel #(.RW(RW), .NR(NR)) u_sel (
    .tick_en (tick_en),
    .res     (cur_dec.res),
    .tick    (sel_tick)
  );

  wdt_countdown #(.MW(MW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_wr),
    .load_arm (new_dec.arm),
    .load_val (new_dec.mult),
    .tick     (sel_tick && cur_dec.res_ok),
    .expire   (expire)
  );

  assign set_ev = (cfg_wr && new_dec.fire_now) || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q <= cfg_wdata;
        irq_q <= new_dec.fire_now;
      end else if (expire) begin
        irq_q <= 1'b1;
      end
      if (set_ev)
        flag_q <= 1'b1;
      else if (flag_rd)
        flag_q <= 1'b0;
    end
  end

  assign cfg_rdata = cfg_q;
  assign wdt_irq   = irq_q;
  assign wdt_flag  = flag_q;
endmodule

// File: rtl/wdt_resmul_chk.sv
module wdt_resmul_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] tick_en,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic       flag_rd,
  input logic [7:0] cfg_rdata,
  input logic       wdt_irq,
  input logic       wdt_flag
);
  logic [2:0] wr_res;
  logic [2:0] cur_res;
  logic       wr_imm;

  assign wr_res  = {cfg_wdata[7], cfg_wdata[1:0]};
  assign cur_res = {cfg_rdata[7], cfg_rdata[1:0]};
  assign wr_imm  = (cfg_wdata[6:2] == 5'd0) && (wr_res != 3'd0) && (wr_res < 3'd5);

  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> ($past(cfg_wr) || $past(|tick_en)));

  p_bad_res_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cur_res > 3'd4) |=> !$rose(wdt_irq));

  p_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wr_imm) |=> (wdt_irq && wdt_flag));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wr_imm) |=> !wdt_irq);

  p_zero_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cfg_rdata == 8'h00) |=> !$rose(wdt_irq));

  p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_flag) |-> $past(flag_rd));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq && !cfg_wr) |=> wdt_irq);

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> wdt_flag);
endmodule

bind wdt_resmul wdt_resmul_chk u_chk (.*);

// File: tb/test_wdt_resmul.sv
module test_wdt_resmul;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tick_en = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       flag_rd = 1'b0;
  logic [7:0] cfg_rdata;
  logic       wdt_irq;
  logic       wdt_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_cfg;
  int         m_cnt;
  bit         m_run;
  bit         m_irq;
  bit         m_flag;

  always #2 clk = ~clk;

  wdt_resmul i_wdt_resmul (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .flag_rd(flag_rd), .cfg_rdata(cfg_rdata),
    .wdt_irq(wdt_irq), .wdt_flag(wdt_flag)
  );

  function automatic int res_of(logic [7:0] v);
    return int'({v[7], v[1:0]});
  endfunction

  function automatic int mult_of(logic [7:0] v);
    return int'(v[6:2]);
  endfunction

  task automatic model_step(bit wr, logic [7:0] d, bit rd, logic [4:0] tk);
    bit set_ev = 0;
    int r;
    if (wr) begin
      m_cfg = d;
      m_irq = 0;
      m_cnt = mult_of(d);
      r = res_of(d);
      m_run = 0;
      if (d != 8'h00 && r <= 4) begin
        if (m_cnt == 0) begin
          m_irq = 1;
          set_ev = 1;
        end else begin
          m_run = 1;
        end
      end
    end else if (m_run && tk[res_of(m_cfg)]) begin
      if (m_cnt == 1) begin
        m_run = 0;
        m_irq = 1;
        set_ev = 1;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (set_ev) m_flag = 1;
    else if (rd) m_flag = 0;
  endtask

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    check_bit(tag, "wdt_irq", wdt_irq, m_irq);
    check_bit(tag, "wdt_flag", wdt_flag, m_flag);
    checks++;
    if (cfg_rdata !== m_cfg) begin
      errors++;
      $display("FAIL %s cfg_rdata actual=%02h expected=%02h at %0t", tag, cfg_rdata, m_cfg, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after comparing.
  task automatic step(string tag, bit wr, logic [7:0] d, bit rd, logic [4:0] tk);
    cfg_wr = wr; cfg_wdata = d; flag_rd = rd; tick_en = tk;
    @(posedge clk);
    model_step(wr, d, rd, tk);
    @(negedge clk);
    cfg_wr = 0; flag_rd = 0; tick_en = '0;
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cfg = 0; m_cnt = 0; m_run = 0; m_irq = 0; m_flag = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) step("R1", 0, 8'h00, 0, 5'b11111);
    check_bit("R1", "irq idle after reset", wdt_irq, 1'b0);

    // R2: 0x0E = multiplier 3, 1 s resolution; other lines ignored
    step("R2", 1, 8'h0E, 0, 5'b00000);
    step("R2", 0, 8'h00, 0, 5'b11011);
    step("R2", 0, 8'h00, 0, 5'b00100);
    step("R2", 0, 8'h00, 0, 5'b00100);
    check_bit("R2", "irq before third tick", wdt_irq, 1'b0);
    step("R2", 0, 8'h00, 0, 5'b00100);
    check_bit("R2", "irq on third tick", wdt_irq, 1'b1);
    check_bit("R2", "flag on third tick", wdt_flag, 1'b1);

    // R7 / R8: read clears flag, irq held, counter halted
    step("R7", 0, 8'h00, 1, 5'b00000);
    check_bit("R7", "flag after read", wdt_flag, 1'b0);
    check_bit("R8", "irq held after read", wdt_irq, 1'b1);
    for (int i = 0; i < 8; i++) step("R8", 0, 8'h00, 0, 5'b11111);
    check_bit("R8", "no re-trigger", wdt_flag, 1'b0);

    // R5: write clears irq
    step("R5", 1, 8'h0E, 0, 5'b00000);
    check_bit("R5", "irq after write", wdt_irq, 1'b0);

    // R3: undefined resolution codes 5 and 7
    step("R3", 1, 8'h85, 0, 5'b00000);
    for (int i = 0; i < 12; i++) step("R3", 0, 8'h00, 0, 5'b11111);
    check_bit("R3", "code 5 silent", wdt_irq, 1'b0);
    step("R3", 1, 8'h83, 0, 5'b00000);
    for (int i = 0; i < 12; i++) step("R3", 0, 8'h00, 0, 5'b11111);
    check_bit("R3", "code 7 silent", wdt_irq, 1'b0);

    // R4: zero multiplier, codes 1 and 4
    step("R4", 1, 8'h01, 1, 5'b00000);
    check_bit("R4", "immediate code 1 irq", wdt_irq, 1'b1);
    check_bit("R4", "immediate code 1 flag", wdt_flag, 1'b1);
    step("R4", 0, 8'h00, 1, 5'b00000);
    step("R4", 1, 8'h80, 0, 5'b00000);
    check_bit("R4", "immediate code 4 irq", wdt_irq, 1'b1);

    // R6: 00h disables
    step("R6", 1, 8'h00, 1, 5'b00000);
    for (int i = 0; i < 12; i++) step("R6", 0, 8'h00, 0, 5'b11111);
    check_bit("R6", "disabled irq", wdt_irq, 1'b0);
    check_bit("R6", "disabled flag", wdt_flag, 1'b0);

    // R9: tick with the write is not counted (0x09 = mult 2, code 1)
    step("R9", 1, 8'h09, 0, 5'b00010);
    step("R9", 0, 8'h00, 0, 5'b00010);
    check_bit("R9", "one tick not enough", wdt_irq, 1'b0);
    step("R9", 0, 8'h00, 0, 5'b00010);
    check_bit("R9", "second tick expires", wdt_irq, 1'b1);

    // R7: expiry wins over simultaneous read (0x05 = mult 1, code 1)
    step("R7", 0, 8'h00, 1, 5'b00000);
    step("R7", 1, 8'h05, 0, 5'b00000);
    step("R7", 0, 8'h00, 1, 5'b00010);
    check_bit("R7", "set beats read", wdt_flag, 1'b1);

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit wr = ($urandom_range(0, 29) == 0);
      bit rd = ($urandom_range(0, 9) == 0);
      logic [4:0] tk;
      logic [2:0] rs = 3'($urandom_range(0, 7));
      logic [4:0] ml = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31))
                                                   : 5'($urandom_range(0, 3));
      logic [7:0] d = {rs[2], ml, rs[1:0]};
      for (int b = 0; b < 5; b++) tk[b] = ($urandom_range(0, 2) == 0);
      step("R2", wr, d, rd, tk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule